// File: doc/BRIEF.md
# Multi-Source Hard Reset Sequencer

This block takes several reset requests and turns them into one timed, active-low hard reset pulse. The requests come from a power-up pulse, per-rail undervoltage flags, a software reset line, a watchdog-timeout pulse and an external reset line. Each request belongs to one of two classes. Power and undervoltage requests are slow: the hard reset starts after a long delay. Software, watchdog and external requests are fast: the hard reset starts after a short delay. After the delay the hard reset is held low for a fixed number of ticks.

All delays count pulses of a 1 ms enable input (`tick_ms`), so a bench or a system can scale time freely. The block also forms a combined reset, which is the hard reset ANDed with an active-low soft reset level from elsewhere. It drives a DAC output-connect signal. That signal keeps the analog output tied to ground while the combined reset is active. It also keeps the output grounded after the reset ends, until the processor writes to the DAC.

Top module: `hard_reset_seq`

## Requirements
- R1: A slow-class request starts a wait of LONG_MS ticks (default 400). A slow-class request is a one-cycle high on `pwr_up`, or a 0-to-1 change of any synchronized bit of `uv_fail`. At the end of the wait, `hard_rst_n` goes low at the clock edge that samples the LONG_MS-th tick, and it is high throughout the wait.
- R2: A fast-class request starts a wait of SHORT_MS ticks (default 200). A fast-class request is a one-cycle high on `wdog_to`, a 1-to-0 change of `sw_rst_n`, or a 1-to-0 change of synchronized `ext_rst_n`. When both classes arrive in the same cycle, the fast delay is used.
- R3: `hard_rst_n` stays low for HOLD_MS ticks (default 300). HOLD_MS is clamped to the range 200..400, so a value of 150 gives a hold of 200 ticks.
- R4: A request that arrives while a wait is already running is ignored. `hard_rst_n` still falls at the tick set by the first request.
- R5: A request that arrives while `hard_rst_n` is low restarts the hold. `hard_rst_n` then stays low for HOLD_MS ticks after that request.
- R6: `any_rst_n` equals `hard_rst_n` AND `soft_rst_n` in the same cycle. In any cycle that ends with `any_rst_n` low, `dac_conn` goes to 0 at that clock edge.
- R7: Once `any_rst_n` is high again, `dac_conn` stays 0 until `dac_wr` is sampled high with `any_rst_n` high. `dac_conn` becomes 1 at that edge and stays 1 until the combined reset goes low again.
- R8: `uv_fail` and `ext_rst_n` each pass through two flip-flops before edge detection. Their requests therefore take effect two cycles later than the same request on `pwr_up`, `wdog_to` or `sw_rst_n`.
- R9: While `rst` is high and right after it: the sequence is idle, `hard_rst_n` is 1 and `dac_conn` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-cycle enable, once per millisecond |
| pwr_up | input | 1 | Power-up request pulse (slow class) |
| uv_fail | input | N_RAILS | Per-rail undervoltage flags, asynchronous |
| sw_rst_n | input | 1 | Software reset request, active low |
| wdog_to | input | 1 | Watchdog-timeout pulse (fast class) |
| ext_rst_n | input | 1 | External reset line, active low, asynchronous |
| soft_rst_n | input | 1 | Soft reset level, active low |
| dac_wr | input | 1 | DAC write strobe from the processor bus |
| hard_rst_n | output | 1 | Timed hard reset, active low |
| any_rst_n | output | 1 | Hard OR soft reset, active low |
| dac_conn | output | 1 | 1 connects the DAC output; 0 clamps it to analog ground |

## Verification
A request on `pwr_up`, `wdog_to` or `sw_rst_n` is registered at the next rising edge and starts the wait there. A request on `uv_fail` or `ext_rst_n` starts the wait two edges later. `hard_rst_n` changes at the edge that samples the last counted tick. `any_rst_n` follows `soft_rst_n` in the same cycle. `dac_conn` changes one edge after the write or reset that drives it. The bench keeps a cycle-level reference model that is updated at each rising edge. It compares all three outputs at the following falling edge, after both the design and the model have settled, and it drives new inputs only after that comparison.

// File: rtl/hrs_pkg.sv
package hrs_pkg;

    localparam int unsigned HOLD_FLOOR_MS = 200;
    localparam int unsigned HOLD_CEIL_MS  = 400;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_WAIT = 2'd1,
        SEQ_HOLD = 2'd2
    } seq_state_e;

    // request classes seen in one cycle
    typedef struct packed {
        logic slow;   // power / undervoltage
        logic fast;   // software / watchdog / external
    } req_s;

    function automatic int unsigned clamp_hold(int unsigned v);
        if (v < HOLD_FLOOR_MS) return HOLD_FLOOR_MS;
        if (v > HOLD_CEIL_MS)  return HOLD_CEIL_MS;
        return v;
    endfunction

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/hrs_sync.sv
module hrs_sync #(
    parameter int   W       = 1,
    parameter logic RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= {W{RST_VAL}};
            q    <= {W{RST_VAL}};
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/hrs_req_merge.sv
module hrs_req_merge
    import hrs_pkg::*;
#(
    parameter int N_RAILS = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pwr_up,
    input  logic [N_RAILS-1:0] uv_s,
    input  logic               sw_rst_n,
    input  logic               wdog_to,
    input  logic               ext_s_n,
    output req_s               req
);
    logic [N_RAILS-1:0] uv_d;
    logic [N_RAILS-1:0] uv_rise;
    logic               sw_d;
    logic               ext_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            uv_d  <= '0;
            sw_d  <= 1'b1;
            ext_d <= 1'b1;
        end else begin
            uv_d  <= uv_s;
            sw_d  <= sw_rst_n;
            ext_d <= ext_s_n;
        end
    end

    for (genvar i = 0; i < N_RAILS; i++) begin : g_rail
        assign uv_rise[i] = uv_s[i] & ~uv_d[i];
    end

    always_comb begin
        req.slow = pwr_up | (|uv_rise);
        req.fast = wdog_to | (sw_d & ~sw_rst_n) | (ext_d & ~ext_s_n);
    end
endmodule

// File: rtl/hrs_timer.sv
module hrs_timer
    import hrs_pkg::*;
#(
    parameter int unsigned LONG_TICKS  = 400,
    parameter int unsigned SHORT_TICKS = 200,
    parameter int unsigned HOLD_TICKS  = 300
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  req_s req,
    output logic hard_rst_n
);
    localparam int unsigned MAX_TICKS = max3(LONG_TICKS, SHORT_TICKS, HOLD_TICKS);
    localparam int          CNT_W     = $clog2(MAX_TICKS + 1);

    seq_state_e       st;
    logic [CNT_W-1:0] cnt;
    logic             last;

    assign last = (cnt == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= SEQ_IDLE;
            cnt <= '0;
        end else begin
            unique case (st)
                SEQ_IDLE: begin
                    if (req.fast) begin
                        st  <= SEQ_WAIT;
                        cnt <= CNT_W'(SHORT_TICKS);
                    end else if (req.slow) begin
                        st  <= SEQ_WAIT;
                        cnt <= CNT_W'(LONG_TICKS);
                    end
                end
                SEQ_WAIT: begin
                    if (tick) begin
                        if (last) begin
                            st  <= SEQ_HOLD;
                            cnt <= CNT_W'(HOLD_TICKS);
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                end
                SEQ_HOLD: begin
                    if (req.fast | req.slow) begin
                        cnt <= CNT_W'(HOLD_TICKS);
                    end else if (tick) begin
                        if (last) begin
                            st  <= SEQ_IDLE;
                            cnt <= '0;
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                end
                default: begin
                    st  <= SEQ_IDLE;
                    cnt <= '0;
                end
            endcase
        end
    end

    assign hard_rst_n = (st != SEQ_HOLD);
endmodule

// File: rtl/hrs_dac_gate.sv
module hrs_dac_gate (
    input  logic clk,
    input  logic rst,
    input  logic any_rst_n,
    input  logic dac_wr,
    output logic dac_conn
);
    always_ff @(posedge clk) begin
        if (rst)             dac_conn <= 1'b0;
        else if (!any_rst_n) dac_conn <= 1'b0;
        else if (dac_wr)     dac_conn <= 1'b1;
    end
endmodule

// File: rtl/hard_reset_seq.sv
module hard_reset_seq
    import hrs_pkg::*;
#(
    parameter int N_RAILS  = 4,
    parameter int LONG_MS  = 400,
    parameter int SHORT_MS = 200,
    parameter int HOLD_MS  = 300
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick_ms,
    input  logic               pwr_up,
    input  logic [N_RAILS-1:0] uv_fail,
    input  logic               sw_rst_n,
    input  logic               wdog_to,
    input  logic               ext_rst_n,
    input  logic               soft_rst_n,
    input  logic               dac_wr,
    output logic               hard_rst_n,
    output logic               any_rst_n,
    output logic               dac_conn
);
    localparam int unsigned HOLD_TICKS = clamp_hold(HOLD_MS);

    logic [N_RAILS-1:0] uv_s;
    logic               ext_s_n;
    req_s               req;

    hrs_sync #(.W(N_RAILS), .RST_VAL(1'b0)) u_uv_sync (
        .clk(clk), .rst(rst), .d(uv_fail), .q(uv_s)
    );

    hrs_sync #(.W(1), .RST_VAL(1'b1)) u_ext_sync (
        .clk(clk), .rst(rst), .d(ext_rst_n), .q(ext_s_n)
    );

    hrs_req_merge #(.N_RAILS(N_RAILS)) u_merge (
        .clk(clk), .rst(rst), .pwr_up(pwr_up), .uv_s(uv_s),
        .sw_rst_n(sw_rst_n), .wdog_to(wdog_to), .ext_s_n(ext_s_n), .req(req)
    );

    hrs_timer #(
        .LONG_TICKS(LONG_MS), .SHORT_TICKS(SHORT_MS), .HOLD_TICKS(HOLD_TICKS)
    ) u_timer (
        .clk(clk), .rst(rst), .tick(tick_ms), .req(req), .hard_rst_n(hard_rst_n)
    );

    assign any_rst_n = hard_rst_n & soft_rst_n;

    hrs_dac_gate u_gate (
        .clk(clk), .rst(rst), .any_rst_n(any_rst_n), .dac_wr(dac_wr), .dac_conn(dac_conn)
    );
endmodule

// File: rtl/hard_reset_seq_chk.sv
module hard_reset_seq_chk #(
    parameter int HOLD_TICKS = 300
) (
    input logic clk,
    input logic rst,
    input logic tick,
    input logic restart,
    input logic hard_rst_n,
    input logic any_rst_n,
    input logic dac_wr,
    input logic dac_conn
);
    // ticks seen while hard reset is low since the last request
    logic [15:0] low_ticks;

    always_ff @(posedge clk) begin
        if (rst)             low_ticks <= '0;
        else if (hard_rst_n) low_ticks <= '0;
        else if (restart)    low_ticks <= '0;
        else if (tick)       low_ticks <= low_ticks + 16'd1;
    end

    AST_HOLD_CEIL: assert property (@(posedge clk) disable iff (rst)
        low_ticks <= 16'(HOLD_TICKS)); // R3

    AST_HOLD_FULL: assert property (@(posedge clk) disable iff (rst)
        $rose(hard_rst_n) |-> low_ticks == 16'(HOLD_TICKS)); // R5

    AST_FALL_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        $fell(hard_rst_n) |-> $past(tick)); // R1

    AST_DAC_OFF_IN_RST: assert property (@(posedge clk) disable iff (rst)
        !any_rst_n |=> !dac_conn); // R6

    AST_DAC_ON_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
        $rose(dac_conn) |-> ($past(dac_wr) && $past(any_rst_n))); // R7
endmodule

bind hard_reset_seq hard_reset_seq_chk #(.HOLD_TICKS(HOLD_TICKS)) u_chk (
    .clk(clk),
    .rst(rst),
    .tick(tick_ms),
    .restart(req.slow | req.fast),
    .hard_rst_n(hard_rst_n),
    .any_rst_n(any_rst_n),
    .dac_wr(dac_wr),
    .dac_conn(dac_conn)
);

// File: tb/sim_hard_reset_seq.sv
`timescale 1ns/1ps
module sim_hard_reset_seq;
    localparam int NR    = 4;
    localparam int LONG  = 400;
    localparam int SHORT = 200;
    localparam int HOLD  = 300;
    localparam int TDIV  = 3;
    localparam int WDOG_CYCLES = 190000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_ms = 1'b0, pwr_up = 1'b0, sw_rst_n = 1'b1, wdog_to = 1'b0;
    logic ext_rst_n = 1'b1, soft_rst_n = 1'b1, dac_wr = 1'b0;
    logic [NR-1:0] uv_fail = '0;
    logic hard_rst_n, any_rst_n, dac_conn;
    logic hard1, any1, conn1;

    int n_cmp = 0, n_bad = 0, tc = 0;
    bit done = 0;
    string cur_tag = "R9";

    always #2 clk = ~clk;

    hard_reset_seq #(.N_RAILS(NR)) u0 (
        .clk(clk), .rst(rst), .tick_ms(tick_ms), .pwr_up(pwr_up), .uv_fail(uv_fail),
        .sw_rst_n(sw_rst_n), .wdog_to(wdog_to), .ext_rst_n(ext_rst_n),
        .soft_rst_n(soft_rst_n), .dac_wr(dac_wr),
        .hard_rst_n(hard_rst_n), .any_rst_n(any_rst_n), .dac_conn(dac_conn)
    );

    hard_reset_seq #(.N_RAILS(NR), .HOLD_MS(150)) u1 (
        .clk(clk), .rst(rst), .tick_ms(tick_ms), .pwr_up(pwr_up), .uv_fail(uv_fail),
        .sw_rst_n(sw_rst_n), .wdog_to(wdog_to), .ext_rst_n(ext_rst_n),
        .soft_rst_n(soft_rst_n), .dac_wr(dac_wr),
        .hard_rst_n(hard1), .any_rst_n(any1), .dac_conn(conn1)
    );

    function automatic int exp_hold(int v);
        return (v < 200) ? 200 : ((v > 400) ? 400 : v);
    endfunction

    // reference model, built from the requirements
    logic [NR-1:0] m_uvm, m_uvs, m_uvd;
    logic m_exm, m_exs, m_exd, m_swd, m_conn;
    int   m_st, m_cnt;
    logic m_slow, m_fast, m_hard;

    assign m_slow = pwr_up | (|(m_uvs & ~m_uvd));
    assign m_fast = wdog_to | (m_swd & ~sw_rst_n) | (m_exd & ~m_exs);
    assign m_hard = (m_st != 2);

    always @(posedge clk) begin
        if (rst) begin
            m_uvm <= '0; m_uvs <= '0; m_uvd <= '0;
            m_exm <= 1'b1; m_exs <= 1'b1; m_exd <= 1'b1; m_swd <= 1'b1;
            m_st <= 0; m_cnt <= 0; m_conn <= 1'b0;
        end else begin
            m_uvm <= uv_fail; m_uvs <= m_uvm; m_uvd <= m_uvs;
            m_exm <= ext_rst_n; m_exs <= m_exm; m_exd <= m_exs;
            m_swd <= sw_rst_n;
            case (m_st)
                0: if (m_fast) begin m_st <= 1; m_cnt <= SHORT; end
                   else if (m_slow) begin m_st <= 1; m_cnt <= LONG; end
                1: if (tick_ms) begin
                       if (m_cnt == 1) begin m_st <= 2; m_cnt <= exp_hold(HOLD); end
                       else m_cnt <= m_cnt - 1;
                   end
                default: if (m_slow | m_fast) m_cnt <= exp_hold(HOLD);
                   else if (tick_ms) begin
                       if (m_cnt == 1) begin m_st <= 0; m_cnt <= 0; end
                       else m_cnt <= m_cnt - 1;
                   end
            endcase
            if (!(m_hard && soft_rst_n)) m_conn <= 1'b0;
            else if (dac_wr)             m_conn <= 1'b1;
        end
    end

    // hold length meters for both instances (R3)
    bit meas_en = 0;
    int h0 = 0, h1 = 0;
    always @(posedge clk) begin
        if (meas_en && tick_ms && !hard_rst_n) h0 <= h0 + 1;
        if (meas_en && tick_ms && !hard1)      h1 <= h1 + 1;
    end

    task automatic chk(string tag, int act, int exp, string what);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
        if (!rst) begin
            chk(cur_tag, hard_rst_n, m_hard, "hard_rst_n");
            chk("R6", any_rst_n, m_hard && soft_rst_n, "any_rst_n");
            chk("R7", dac_conn, m_conn, "dac_conn");
        end
        tc = (tc + 1) % TDIV;
        tick_ms = (tc == 0);
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic pulse_pwr();   step(); pwr_up = 1'b1;  step(); pwr_up = 1'b0;  endtask
    task automatic pulse_wdog();  step(); wdog_to = 1'b1; step(); wdog_to = 1'b0; endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        run(6);
        // R9 reset state, sampled while rst is high
        chk("R9", hard_rst_n, 1, "hard_rst_n in reset");
        chk("R9", dac_conn, 0, "dac_conn in reset");
        step(); rst = 1'b0;
        step();
        chk("R9", hard_rst_n, 1, "hard_rst_n after reset");
        chk("R9", dac_conn, 0, "dac_conn after reset");

        // R1 + R3: power-up path and hold length, including the clamp
        cur_tag = "R1";
        h0 = 0; h1 = 0; meas_en = 1;
        pulse_pwr();
        run((LONG + HOLD) * TDIV + 30);
        meas_en = 0;
        chk("R3", h0, exp_hold(HOLD), "hold ticks default");
        chk("R3", h1, exp_hold(150), "hold ticks clamped");

        // R7: reconnect only on a write after reset ends
        step();
        chk("R7", dac_conn, 0, "dac_conn before write");
        dac_wr = 1'b1; step(); dac_wr = 1'b0;
        chk("R7", dac_conn, 1, "dac_conn after write");
        soft_rst_n = 1'b0; step();
        chk("R6", any_rst_n, 0, "any_rst_n under soft reset");
        chk("R6", dac_conn, 0, "dac_conn under soft reset");
        dac_wr = 1'b1; step(); dac_wr = 1'b0;
        chk("R7", dac_conn, 0, "write ignored during reset");
        soft_rst_n = 1'b1; run(3);
        chk("R7", dac_conn, 0, "stays clamped after reset");

        // R8: external line through the synchronizer
        cur_tag = "R8";
        step(); ext_rst_n = 1'b0; run(5); ext_rst_n = 1'b1;
        run((SHORT + HOLD) * TDIV + 30);

        // R2: both classes in one cycle pick the short delay
        cur_tag = "R2";
        step(); pwr_up = 1'b1; sw_rst_n = 1'b0; step(); pwr_up = 1'b0;
        run(3); sw_rst_n = 1'b1;
        run(SHORT * TDIV + 6);
        chk("R2", hard_rst_n, 0, "low after short delay");
        run(HOLD * TDIV + 30);

        // R4: a slow request during a fast wait is ignored
        cur_tag = "R4";
        pulse_wdog();
        run(100 * TDIV);
        uv_fail[2] = 1'b1;
        run((SHORT - 100) * TDIV + 6);
        chk("R4", hard_rst_n, 0, "first schedule kept");
        run(HOLD * TDIV + 30);
        uv_fail[2] = 1'b0;
        run(10);

        // R5: request during hold restarts it
        cur_tag = "R5";
        pulse_wdog();
        run((SHORT + 50) * TDIV);
        uv_fail[1] = 1'b1;
        run((HOLD - 20) * TDIV);
        chk("R5", hard_rst_n, 0, "hold restarted");
        run(40 * TDIV);
        uv_fail[1] = 1'b0;
        run(10);

        // random mix (R1 tag for hard_rst_n comparisons)
        cur_tag = "R1";
        begin
            int sw_cd = 0, ex_cd = 0;
            for (int k = 0; k < 60000; k++) begin
                int r;
                step();
                r = $urandom_range(0, 2999);
                pwr_up  = (r == 0);
                wdog_to = (r == 1);
                if (r == 2) sw_cd = 3;
                if (r == 3) ex_cd = 5;
                if (r == 4) uv_fail[$urandom_range(0, NR-1)] ^= 1'b1;
                sw_rst_n  = (sw_cd == 0);
                ext_rst_n = (ex_cd == 0);
                if (sw_cd > 0) sw_cd--;
                if (ex_cd > 0) ex_cd--;
                if ($urandom_range(0, 1999) == 0) soft_rst_n = ~soft_rst_n;
                dac_wr = ($urandom_range(0, 39) == 0);
            end
        end
        run(4);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (WDOG_CYCLES) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule